// File: doc/BRIEF.md
# Packed Lane Shift, Rotate and Permute Unit

This block is a single-stage SIMD datapath for 64-bit operands. It shifts left or right, logically or arithmetically, and rotates right. Each of these acts separately on every 16-bit, 32-bit or 64-bit lane, so bits never spill into a neighbouring lane. It can also permute the four halfwords of operand a under an 8-bit immediate, or extract eight consecutive bytes from the 128-bit pair formed by operands b (upper) and a (lower). Every result comes with a 32-bit negative/zero status word whose layout matches the one the companion lane ALU produces.

A request is presented with `in_valid` for one cycle. One clock edge later the result, its status and `out_valid` appear on registered outputs. A small two-state output machine tracks whether the output registers hold a fresh result. In state EMPTY, `in_valid` high moves it to FULL (EMPTY->FULL), and `in_valid` low keeps it in EMPTY. In state FULL, another `in_valid` keeps it in FULL (FULL->FULL), and `in_valid` low returns it to EMPTY (FULL->EMPTY). Reset forces EMPTY. In either state, the data and status registers change only when `in_valid` is high.

Top module: `pshift_unit`

## Requirements
- R1: A request accepted with `in_valid` high at a clock edge produces `out_valid` high after that edge, with the matching result on `out_data` and status on `out_flags`. `out_valid` is low after any edge at which `in_valid` was low, and `out_data`/`out_flags` then keep their previous values.
- R2: After reset, `out_valid`, `out_data` and `out_flags` are all zero.
- R3: Op code 0 is a logical left shift and op code 1 a logical right shift, by `amount` (0 to 63), on each lane. The lane width is 16 bits for `size` 0, 32 bits for `size` 1, and 64 bits for `size` 2 or 3. Bits shifted out of a lane are lost and zeros fill in, so any count at or beyond the lane width gives an all-zero lane.
- R4: Op code 2 is an arithmetic right shift on each lane that fills with that lane's own top bit; any count at or beyond the lane width gives a lane made entirely of copies of the sign bit.
- R5: Op code 3 rotates each lane right by `amount` modulo the lane width, so the low bits of the lane move to its top. An effective count of zero leaves the lane unchanged.
- R6: Op code 4 builds result halfword k (bits 16k+15:16k, k = 0..3) from halfword `ctrl[2k+1:2k]` of operand a.
- R7: Op code 5 returns bytes n to n+7 of the 128-bit value {b, a}, with n = `amount[2:0]`; n = 0 returns operand a unchanged.
- R8: The status word holds, for lane i of a result split into L lanes, the lane's top bit at bit (i+1)*(32/L)-1 and a lane-is-zero flag at bit (i+1)*(32/L)-2. All other status bits are zero. Shifts and rotates use their `size`, op code 4 uses 16-bit lanes, and op code 5 uses one 64-bit lane (bits 31 and 30).
- R9: Op codes 6 and 7 pass operand a through unchanged, with status computed as one 64-bit lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code |
| size | input | 2 | Lane size for shifts and rotates |
| amount | input | 6 | Shift, rotate or byte-align count |
| ctrl | input | 8 | Halfword selection immediate |
| opa | input | 64 | Operand a |
| opb | input | 64 | Operand b (byte-align only) |
| out_valid | output | 1 | Result registers hold a fresh result |
| out_data | output | 64 | Registered result |
| out_flags | output | 32 | Registered negative/zero status |

## Verification
The hardest behaviour to reach is the saturating edge of the count. A 6-bit count can exceed a 16-bit or 32-bit lane, and the design must then clear the lane, fill it with the sign, or reduce the count modulo the width. None of this shows up with small counts. Directed vectors therefore pair counts of exactly the lane width, beyond it, and 63 with lanes whose top bits differ. A long run of random operations covering every op, size and full 6-bit count follows, with each result compared against a bit-by-bit model that works only from the requirements.

// File: rtl/pshift_pkg.sv
package pshift_pkg;

    localparam int DATA_W = 64;
    localparam int FLAG_W = 32;
    localparam int CNT_W  = 6;
    localparam int HALF_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        OP_SLL   = 3'd0,
        OP_SRL   = 3'd1,
        OP_SRA   = 3'd2,
        OP_ROR   = 3'd3,
        OP_SHUF  = 3'd4,
        OP_ALIGN = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SZ_16  = 2'd0,
        SZ_32  = 2'd1,
        SZ_64  = 2'd2,
        SZ_64X = 2'd3
    } size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } state_e;

endpackage

// File: rtl/pshift_lane.sv
module pshift_lane #(
    parameter int LANE_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic [2:0]        op,
    input  logic [CNT_W-1:0]  count,
    input  logic [LANE_W-1:0] lane_in,
    output logic [LANE_W-1:0] lane_out
);
    import pshift_pkg::*;

    localparam int ROT_W = $clog2(LANE_W);

    logic [2*LANE_W-1:0] doubled;
    logic [ROT_W-1:0]    rot_cnt;

    // rotate: shift a doubled copy so low bits wrap to the top of the lane
    assign rot_cnt = count[ROT_W-1:0];
    assign doubled = {lane_in, lane_in} >> rot_cnt;

    always_comb begin
        unique case (op_e'(op))
            OP_SLL:  lane_out = lane_in << count;
            OP_SRL:  lane_out = lane_in >> count;
            OP_SRA:  lane_out = $signed(lane_in) >>> count;
            OP_ROR:  lane_out = doubled[LANE_W-1:0];
            default: lane_out = lane_in;
        endcase
    end
endmodule

// File: rtl/pshift_bank.sv
module pshift_bank #(
    parameter int DATA_W = 64,
    parameter int LANE_W = 16,
    parameter int CNT_W  = 6
) (
    input  logic [2:0]        op,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] src,
    output logic [DATA_W-1:0] res
);
    localparam int NLANES = DATA_W / LANE_W;

    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        pshift_lane #(
            .LANE_W (LANE_W),
            .CNT_W  (CNT_W)
        ) u_lane (
            .op       (op),
            .count    (count),
            .lane_in  (src[i*LANE_W +: LANE_W]),
            .lane_out (res[i*LANE_W +: LANE_W])
        );
    end
endmodule

// File: rtl/pshift_permute.sv
module pshift_permute #(
    parameter int DATA_W = 64,
    parameter int HALF_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0]                      opa,
    input  logic [DATA_W-1:0]                      opb,
    input  logic [2*(DATA_W/HALF_W)-1:0]           ctrl,
    input  logic [$clog2(DATA_W/BYTE_W)-1:0]       byte_cnt,
    output logic [DATA_W-1:0]                      shuf_res,
    output logic [DATA_W-1:0]                      align_res
);
    localparam int NHALF = DATA_W / HALF_W;
    localparam int SEL_W = $clog2(NHALF);

    logic [2*DATA_W-1:0] pair;
    logic [2*DATA_W-1:0] pair_shifted;

    // halfword shuffle: one selector field per destination halfword
    for (genvar k = 0; k < NHALF; k++) begin : g_half
        logic [SEL_W-1:0] sel;
        assign sel = ctrl[k*SEL_W +: SEL_W];
        assign shuf_res[k*HALF_W +: HALF_W] = opa[sel*HALF_W +: HALF_W];
    end

    // byte-align funnel over the concatenated pair
    assign pair         = {opb, opa};
    assign pair_shifted = pair >> (byte_cnt * BYTE_W);
    assign align_res    = pair_shifted[DATA_W-1:0];
endmodule

// File: rtl/pshift_flags.sv
module pshift_flags #(
    parameter int DATA_W = 64,
    parameter int FLAG_W = 32
) (
    input  logic [1:0]        fsize,
    input  logic [DATA_W-1:0] data,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] by_size [3];

    // g = 0: 16-bit lanes, 1: 32-bit lanes, 2: one 64-bit lane
    for (genvar g = 0; g < 3; g++) begin : g_size
        localparam int LW = 16 << g;
        localparam int NL = DATA_W / LW;
        localparam int SP = FLAG_W / NL;
        for (genvar i = 0; i < NL; i++) begin : g_lane
            assign by_size[g][(i+1)*SP-1] = data[i*LW + LW - 1];
            assign by_size[g][(i+1)*SP-2] = (data[i*LW +: LW] == '0);
            if (SP > 2) begin : g_pad
                assign by_size[g][i*SP +: SP-2] = '0;
            end
        end
    end

    always_comb begin
        unique case (fsize)
            2'd0:    flags = by_size[0];
            2'd1:    flags = by_size[1];
            default: flags = by_size[2];
        endcase
    end
endmodule

// File: rtl/pshift_unit.sv
module pshift_unit
    import pshift_pkg::*;
#(
    parameter int P_DATA_W = 64,
    parameter int P_FLAG_W = 32,
    parameter int P_CNT_W  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2:0]          op,
    input  logic [1:0]          size,
    input  logic [P_CNT_W-1:0]  amount,
    input  logic [7:0]          ctrl,
    input  logic [P_DATA_W-1:0] opa,
    input  logic [P_DATA_W-1:0] opb,
    output logic                out_valid,
    output logic [P_DATA_W-1:0] out_data,
    output logic [P_FLAG_W-1:0] out_flags
);
    localparam int NSIZE  = 3;
    localparam int BCNT_W = $clog2(P_DATA_W / BYTE_W);

    logic [P_DATA_W-1:0] bank_res [NSIZE];
    logic [P_DATA_W-1:0] shuf_res;
    logic [P_DATA_W-1:0] align_res;
    logic [P_DATA_W-1:0] result;
    logic [1:0]          flag_size;
    logic [P_FLAG_W-1:0] flags_comb;

    state_e state_q, state_d;

    for (genvar g = 0; g < NSIZE; g++) begin : g_bank
        pshift_bank #(
            .DATA_W (P_DATA_W),
            .LANE_W (16 << g),
            .CNT_W  (P_CNT_W)
        ) u_bank (
            .op    (op),
            .count (amount),
            .src   (opa),
            .res   (bank_res[g])
        );
    end

    pshift_permute #(
        .DATA_W (P_DATA_W),
        .HALF_W (HALF_W),
        .BYTE_W (BYTE_W)
    ) u_perm (
        .opa       (opa),
        .opb       (opb),
        .ctrl      (ctrl),
        .byte_cnt  (amount[BCNT_W-1:0]),
        .shuf_res  (shuf_res),
        .align_res (align_res)
    );

    always_comb begin
        unique case (op_e'(op))
            OP_SLL, OP_SRL, OP_SRA, OP_ROR: begin
                unique case (size_e'(size))
                    SZ_16:   result = bank_res[0];
                    SZ_32:   result = bank_res[1];
                    default: result = bank_res[2];
                endcase
                flag_size = (size == 2'd3) ? 2'd2 : size;
            end
            OP_SHUF: begin
                result    = shuf_res;
                flag_size = 2'd0;
            end
            OP_ALIGN: begin
                result    = align_res;
                flag_size = 2'd2;
            end
            default: begin
                result    = opa;
                flag_size = 2'd2;
            end
        endcase
    end

    pshift_flags #(
        .DATA_W (P_DATA_W),
        .FLAG_W (P_FLAG_W)
    ) u_flags (
        .fsize (flag_size),
        .data  (result),
        .flags (flags_comb)
    );

    // next-state logic of the output-occupancy machine
    always_comb begin
        unique case (state_q)
            ST_EMPTY: state_d = in_valid ? ST_FULL  : ST_EMPTY;
            ST_FULL:  state_d = in_valid ? ST_FULL  : ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_flags <= '0;
        end else if (in_valid) begin
            out_data  <= result;
            out_flags <= flags_comb;
        end
    end

    assign out_valid = (state_q == ST_FULL);
endmodule

// File: rtl/pshift_unit_checker.sv
module pshift_unit_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  op,
    input logic [1:0]  size,
    input logic [5:0]  amount,
    input logic [63:0] opa,
    input logic        out_valid,
    input logic [63:0] out_data,
    input logic [31:0] out_flags
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_flags))); // R1

    AST_FLAG_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_flags & 32'h3F3F_3F3F) == 32'h0); // R8

    AST_SLL16_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd0 && size == 2'd0 && amount >= 6'd16)
        |=> (out_data == 64'h0)); // R3

    AST_ALIGN_ZERO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 3'd5 && amount[2:0] == 3'd0)
        |=> (out_data == $past(opa))); // R7
endmodule

bind pshift_unit pshift_unit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .size      (size),
    .amount    (amount),
    .opa       (opa),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_flags (out_flags)
);

// File: tb/pshift_unit_test.sv
`timescale 1ns/1ps
module pshift_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [5:0]  amount = '0;
    logic [7:0]  ctrl = '0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [31:0] out_flags;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pshift_unit uut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .op (op),
        .size (size), .amount (amount), .ctrl (ctrl), .opa (opa), .opb (opb),
        .out_valid (out_valid), .out_data (out_data), .out_flags (out_flags)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // bit-by-bit model written from the requirements
    function automatic logic [63:0] model_data(input logic [2:0] o, input logic [1:0] sz,
                                               input logic [5:0] amt, input logic [7:0] c,
                                               input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        int w;
        int n;
        r = '0;
        w = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
        n = int'(amt);
        if (o <= 3'd3) begin
            for (int i = 0; i < 64 / w; i++) begin
                for (int j = 0; j < w; j++) begin
                    int base;
                    base = i * w;
                    case (o)
                        3'd0: r[base+j] = (j - n >= 0) ? a[base+j-n] : 1'b0;
                        3'd1: r[base+j] = (j + n < w) ? a[base+j+n] : 1'b0;
                        3'd2: r[base+j] = (j + n < w) ? a[base+j+n] : a[base+w-1];
                        default: r[base+j] = a[base + ((j + n) % w)];
                    endcase
                end
            end
        end else if (o == 3'd4) begin
            for (int k = 0; k < 4; k++) begin
                int s;
                s = int'(c[2*k +: 2]);
                r[16*k +: 16] = a[16*s +: 16];
            end
        end else if (o == 3'd5) begin
            for (int k = 0; k < 8; k++) begin
                int idx;
                idx = k + int'(amt[2:0]);
                r[8*k +: 8] = (idx < 8) ? a[8*idx +: 8] : b[8*(idx-8) +: 8];
            end
        end else begin
            r = a;
        end
        return r;
    endfunction

    function automatic logic [31:0] model_flags(input logic [2:0] o, input logic [1:0] sz,
                                                input logic [63:0] d);
        logic [31:0] f;
        int fw;
        int nl;
        int sp;
        f = '0;
        if (o <= 3'd3) fw = (sz == 2'd0) ? 16 : (sz == 2'd1) ? 32 : 64;
        else if (o == 3'd4) fw = 16;
        else fw = 64;
        nl = 64 / fw;
        sp = 32 / nl;
        for (int i = 0; i < nl; i++) begin
            logic zero;
            zero = 1'b1;
            for (int j = 0; j < fw; j++) if (d[i*fw+j]) zero = 1'b0;
            f[(i+1)*sp-1] = d[i*fw+fw-1];
            f[(i+1)*sp-2] = zero;
        end
        return f;
    endfunction

    // drive one request, let it register, sample at the following falling edge
    task automatic issue(input logic [2:0] o, input logic [1:0] sz, input logic [5:0] amt,
                         input logic [7:0] c, input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        op = o; size = sz; amount = amt; ctrl = c; opa = a; opb = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic [63:0] d, input logic [31:0] f);
        check({req, " valid"}, 64'(out_valid), 64'd1);
        check({req, " data"}, out_data, d);
        check({req, " flags"}, 64'(out_flags), 64'(f));
    endtask

    task automatic test_reset();
        check("R2 valid", 64'(out_valid), 64'd0);
        check("R2 data", out_data, 64'd0);
        check("R2 flags", 64'(out_flags), 64'd0);
    endtask

    task automatic test_logical();
        issue(3'd1, 2'd0, 6'd4, 8'h00, 64'h1234_8000_FFFF_0001, 64'h0);
        expect_out("R3 srl16", 64'h0123_0800_0FFF_0000, 32'h0000_0040);
        issue(3'd0, 2'd0, 6'd16, 8'h00, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0);
        expect_out("R3 sll16 width", 64'h0, 32'h4040_4040);
        issue(3'd0, 2'd2, 6'd63, 8'h00, 64'h1, 64'h0);
        expect_out("R3 sll64 63", 64'h8000_0000_0000_0000, 32'h8000_0000);
        issue(3'd1, 2'd1, 6'd40, 8'h00, 64'hFFFF_FFFF_8000_0001, 64'h0);
        expect_out("R3 srl32 beyond", 64'h0, 32'h4000_4000);
    endtask

    task automatic test_arith();
        issue(3'd2, 2'd0, 6'd20, 8'h00, 64'h8000_7FFF_FFFF_0001, 64'h0);
        expect_out("R4 sra16 beyond", 64'hFFFF_0000_FFFF_0000, 32'h8040_8040);
        issue(3'd2, 2'd1, 6'd4, 8'h00, 64'h8000_0000_7000_0000, 64'h0);
        expect_out("R4 sra32", 64'hF800_0000_0700_0000, 32'h8000_0000);
    endtask

    task automatic test_rotate();
        issue(3'd3, 2'd1, 6'd36, 8'h00, 64'h0000_000F_1234_5678, 64'h0);
        expect_out("R5 ror32 mod", 64'hF000_0000_8123_4567, 32'h8000_8000);
        issue(3'd3, 2'd0, 6'd32, 8'h00, 64'hABCD_0000_1234_8001, 64'h0);
        expect_out("R5 ror16 zero", 64'hABCD_0000_1234_8001, 32'h8040_0080);
    endtask

    task automatic test_shuffle();
        issue(3'd4, 2'd2, 6'd0, 8'h1B, 64'h4444_3333_2222_1111, 64'h0);
        expect_out("R6 reverse", 64'h1111_2222_3333_4444, 32'h0);
        issue(3'd4, 2'd1, 6'd0, 8'h55, 64'h0000_0000_8888_0000, 64'h0);
        expect_out("R6 broadcast R8", 64'h8888_8888_8888_8888, 32'h8080_8080);
    endtask

    task automatic test_align();
        issue(3'd5, 2'd0, 6'd3, 8'h00, 64'h0706_0504_0302_0100, 64'h0F0E_0D0C_0B0A_0908);
        expect_out("R7 align3", 64'h0A09_0807_0605_0403, 32'h0);
        issue(3'd5, 2'd0, 6'd8, 8'h00, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
        expect_out("R7 align0 R8", 64'h0, 32'h4000_0000);
    endtask

    task automatic test_reserved();
        issue(3'd6, 2'd0, 6'd5, 8'hFF, 64'h8000_0000_0000_0000, 64'h1);
        expect_out("R9 op6", 64'h8000_0000_0000_0000, 32'h8000_0000);
        issue(3'd7, 2'd1, 6'd1, 8'h00, 64'h0, 64'h5);
        expect_out("R9 op7", 64'h0, 32'h4000_0000);
    endtask

    task automatic test_idle_hold();
        logic [63:0] held_d;
        logic [31:0] held_f;
        issue(3'd0, 2'd0, 6'd1, 8'h00, 64'h0001_0002_0003_0004, 64'h0);
        held_d = out_data;
        held_f = out_flags;
        opa = 64'hDEAD_BEEF_DEAD_BEEF;
        op  = 3'd1;
        repeat (3) @(negedge clk);
        check("R1 idle valid", 64'(out_valid), 64'd0);
        check("R1 idle data", out_data, held_d);
        check("R1 idle flags", 64'(out_flags), 64'(held_f));
    endtask

    task automatic test_back_to_back();
        @(negedge clk);
        op = 3'd0; size = 2'd0; amount = 6'd1; opa = 64'h0001_0001_0001_0001;
        in_valid = 1'b1;
        @(negedge clk);
        check("R1 b2b first", out_data, 64'h0002_0002_0002_0002);
        amount = 6'd2;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 b2b valid", 64'(out_valid), 64'd1);
        check("R1 b2b second", out_data, 64'h0004_0004_0004_0004);
    endtask

    task automatic test_random();
        for (int t = 0; t < 400; t++) begin
            logic [2:0]  o;
            logic [1:0]  sz;
            logic [5:0]  amt;
            logic [7:0]  c;
            logic [63:0] a;
            logic [63:0] b;
            logic [63:0] ed;
            o   = 3'($urandom_range(0, 7));
            sz  = 2'($urandom_range(0, 3));
            amt = 6'($urandom_range(0, 63));
            c   = 8'($urandom);
            a   = {32'($urandom), 32'($urandom)};
            b   = {32'($urandom), 32'($urandom)};
            if (t % 7 == 0) a[31:0] = 32'h0;
            ed  = model_data(o, sz, amt, c, a, b);
            issue(o, sz, amt, c, a, b);
            check("R3 R4 R5 R6 R7 R9 random data", out_data, ed);
            check("R8 random flags", 64'(out_flags), 64'(model_flags(o, sz, ed)));
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_logical();
        test_arith();
        test_rotate();
        test_shuffle();
        test_align();
        test_reserved();
        test_idle_hold();
        test_back_to_back();
        test_random();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule